// File: doc/BRIEF.md
# Flash Program/Erase Permission Checker

This block sits between the command decoder of a serial flash device and its array sequencer. For each program or erase command it takes the opcode, the 24-bit byte address and, for programs, the byte count. One clock later it answers with a grant or a reject pulse. It also reports the aligned region the operation would affect: start address, length in bytes and last byte address. The array is 2 Mbytes. Permission is checked against thirty-two 64-Kbyte protection sectors, each holding one protection bit. Erase size is chosen by opcode among 4, 32 and 64 Kbytes, plus a whole-array erase.

The same block holds the protection bits. A control port sets or clears one sector's bit, or all bits at once. A lock-enable flag, together with an active-low write-protect pin, freezes the bits and the flag itself. Performing the array operation and the serial transport are left to neighbouring logic.

Top module: `flash_prot_check`

## Requirements
- R1: Opcode 20h erases 4096 bytes, 52h erases 32768 bytes and D8h erases 65536 bytes. The reported base clears address bits [11:0], [14:0] or [15:0] respectively, and region_last equals base + size - 1. Results appear on the clock edge after the cmd_valid cycle.
- R2: Opcode 02h is a page program. The reported base is the command address, the size is the byte count, and the last byte address wraps within the 256-byte page: bits [20:8] are kept and bits [7:0] become (addr[7:0] + count - 1) mod 256.
- R3: A page program whose byte count is 0 or above 256 is rejected.
- R4: The protection sector is address bits [20:16], with sector 0 at the bottom. Address bits [23:21] affect neither the sector nor the region, and region_base[23:21] is always 0.
- R5: A program or block erase is rejected if its sector's protection bit is 1 and granted otherwise. grant and reject never pulse together.
- R6: Opcode C7h erases the whole array, reporting base 000000h, size 200000h and last 1FFFFFh. It is rejected if any protection bit is set.
- R7: prot_ctl 2'b00 sets the bit of sector prot_sect and 2'b01 clears it. Both act on the edge at the end of the prot_req cycle.
- R8: prot_ctl 2'b10 sets all thirty-two bits and 2'b11 clears all thirty-two bits.
- R9: While the lock enable is 1 and wp_n is 0, protection requests and lock-enable writes are ignored. With wp_n at 1, or the lock enable at 0, they take effect.
- R10: After reset all protection bits are 1, the lock enable is 0, and grant and reject are low.
- R11: A cmd_valid with any other opcode produces neither grant nor reject and leaves the region outputs unchanged.
- R12: A command strobed in the same cycle as a protection request is judged against the protection bits held before that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 8 | Command opcode |
| cmd_addr | input | 24 | Byte address of the command |
| cmd_count | input | 9 | Byte count for page program (1 to 256) |
| prot_req | input | 1 | Protection-change request strobe |
| prot_ctl | input | 2 | 00 set one, 01 clear one, 10 set all, 11 clear all |
| prot_sect | input | 5 | Sector for single-sector requests |
| lock_wr | input | 1 | Write strobe for the lock enable |
| lock_val | input | 1 | Value written to the lock enable |
| wp_n | input | 1 | Write-protect pin, active low |
| grant | output | 1 | Operation permitted, one-cycle pulse |
| reject | output | 1 | Operation refused, one-cycle pulse |
| region_base | output | 24 | Aligned start address of the affected region |
| region_size | output | 22 | Length of the affected region in bytes |
| region_last | output | 24 | Last byte address of the affected region |

## Verification
The bench builds the block with its default parameters: a 24-bit address, a 21-bit array, 64-Kbyte sectors, 256-byte pages and 4/32-Kbyte small and mid erase blocks. These values bring the top sector 31 and the 1FFFFFh end of the array within reach. They also expose the 2^21-byte whole-array size, which needs the extra size bit, and address bits [23:21], which must be ignored. With 256-byte pages, a count of exactly 256 and a start offset near the page end both exercise the in-page wrap.

// File: rtl/flash_prot_pkg.sv
package flash_prot_pkg;

    typedef enum logic [2:0] {
        OPK_NONE,
        OPK_ERASE_S,
        OPK_ERASE_M,
        OPK_ERASE_L,
        OPK_CHIP,
        OPK_PAGE
    } op_kind_e;

    typedef enum logic [1:0] {
        PCTL_SET_ONE = 2'b00,
        PCTL_CLR_ONE = 2'b01,
        PCTL_SET_ALL = 2'b10,
        PCTL_CLR_ALL = 2'b11
    } prot_ctl_e;

    localparam logic [7:0] OPC_ERASE_S = 8'h20;
    localparam logic [7:0] OPC_ERASE_M = 8'h52;
    localparam logic [7:0] OPC_ERASE_L = 8'hD8;
    localparam logic [7:0] OPC_CHIP    = 8'hC7;
    localparam logic [7:0] OPC_PAGE    = 8'h02;

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
    import flash_prot_pkg::*;
#(
    parameter int PAGE_W = 8,
    localparam int CNT_W = PAGE_W + 1
) (
    input  logic [7:0]       op,
    input  logic [CNT_W-1:0] count,
    output op_kind_e         kind,
    output logic             count_ok
);
    localparam logic [CNT_W-1:0] PAGE_BYTES = CNT_W'(1) << PAGE_W;

    always_comb begin
        case (op)
            OPC_ERASE_S: kind = OPK_ERASE_S;
            OPC_ERASE_M: kind = OPK_ERASE_M;
            OPC_ERASE_L: kind = OPK_ERASE_L;
            OPC_CHIP:    kind = OPK_CHIP;
            OPC_PAGE:    kind = OPK_PAGE;
            default:     kind = OPK_NONE;
        endcase
        if (kind == OPK_PAGE) begin
            count_ok = (count != '0) && (count <= PAGE_BYTES);
        end else begin
            count_ok = 1'b1;
        end
    end

endmodule

// File: rtl/flash_region_calc.sv
module flash_region_calc
    import flash_prot_pkg::*;
#(
    parameter int ARRAY_W  = 21,
    parameter int SECT_SH  = 16,
    parameter int PAGE_W   = 8,
    parameter int SMALL_SH = 12,
    parameter int MID_SH   = 15,
    localparam int CNT_W   = PAGE_W + 1,
    localparam int SIZE_W  = ARRAY_W + 1
) (
    input  op_kind_e            kind,
    input  logic [ARRAY_W-1:0]  addr,
    input  logic [CNT_W-1:0]    count,
    output logic [ARRAY_W-1:0]  base,
    output logic [SIZE_W-1:0]   size,
    output logic [ARRAY_W-1:0]  last
);
    logic [SIZE_W-1:0]  span;
    logic [ARRAY_W-1:0] span_lo;
    logic [ARRAY_W-1:0] keep_mask;
    logic [PAGE_W-1:0]  page_end;

    always_comb begin
        case (kind)
            OPK_ERASE_S: span = SIZE_W'(1) << SMALL_SH;
            OPK_ERASE_M: span = SIZE_W'(1) << MID_SH;
            OPK_ERASE_L: span = SIZE_W'(1) << SECT_SH;
            OPK_CHIP:    span = SIZE_W'(1) << ARRAY_W;
            OPK_PAGE:    span = SIZE_W'(count);
            default:     span = '0;
        endcase
        span_lo   = span[ARRAY_W-1:0];
        keep_mask = ~(span_lo - ARRAY_W'(1));
        page_end  = PAGE_W'(addr[PAGE_W-1:0] + count[PAGE_W-1:0] - PAGE_W'(1));
        size      = span;
        if (kind == OPK_PAGE) begin
            base = addr;
            last = {addr[ARRAY_W-1:PAGE_W], page_end};
        end else begin
            base = addr & keep_mask;
            last = base + span_lo - ARRAY_W'(1);
        end
    end

endmodule

// File: rtl/flash_prot_regs.sv
module flash_prot_regs
    import flash_prot_pkg::*;
#(
    parameter int NSECT  = 32,
    localparam int SEL_W = $clog2(NSECT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prot_req,
    input  prot_ctl_e        prot_ctl,
    input  logic [SEL_W-1:0] prot_sect,
    input  logic             lock_wr,
    input  logic             lock_val,
    input  logic             wp_n,
    output logic [NSECT-1:0] prot_bits
);
    typedef struct packed {
        logic [NSECT-1:0] bits;
        logic             lock;
    } pstate_t;

    pstate_t st_d, st_q;
    logic    frozen;

    assign frozen = st_q.lock && !wp_n;

    always_comb begin
        st_d = st_q;
        if (!frozen) begin
            if (prot_req) begin
                case (prot_ctl)
                    PCTL_SET_ONE: st_d.bits[prot_sect] = 1'b1;
                    PCTL_CLR_ONE: st_d.bits[prot_sect] = 1'b0;
                    PCTL_SET_ALL: st_d.bits = '1;
                    default:      st_d.bits = '0;
                endcase
            end
            if (lock_wr) begin
                st_d.lock = lock_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.bits <= '1;
            st_q.lock <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign prot_bits = st_q.bits;

    // R9
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lock && !wp_n) |=> $stable(st_q));

    // R7
    set_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_req && prot_ctl == PCTL_SET_ONE && !(st_q.lock && !wp_n))
        |=> st_q.bits[$past(prot_sect)]);

    // R7
    clr_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_req && prot_ctl == PCTL_CLR_ONE && !(st_q.lock && !wp_n))
        |=> !st_q.bits[$past(prot_sect)]);

    // R8
    set_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_req && prot_ctl == PCTL_SET_ALL && !(st_q.lock && !wp_n))
        |=> (&st_q.bits));

    // R8
    clr_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_req && prot_ctl == PCTL_CLR_ALL && !(st_q.lock && !wp_n))
        |=> (st_q.bits == '0));

endmodule

// File: rtl/flash_prot_check.sv
module flash_prot_check
    import flash_prot_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int ARRAY_W  = 21,
    parameter int SECT_SH  = 16,
    parameter int PAGE_W   = 8,
    parameter int SMALL_SH = 12,
    parameter int MID_SH   = 15,
    localparam int SECT_W  = ARRAY_W - SECT_SH,
    localparam int NSECT   = 1 << SECT_W,
    localparam int CNT_W   = PAGE_W + 1,
    localparam int SIZE_W  = ARRAY_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [CNT_W-1:0]  cmd_count,
    input  logic              prot_req,
    input  logic [1:0]        prot_ctl,
    input  logic [SECT_W-1:0] prot_sect,
    input  logic              lock_wr,
    input  logic              lock_val,
    input  logic              wp_n,
    output logic              grant,
    output logic              reject,
    output logic [ADDR_W-1:0] region_base,
    output logic [SIZE_W-1:0] region_size,
    output logic [ADDR_W-1:0] region_last
);
    typedef struct packed {
        logic               grant;
        logic               reject;
        logic [ARRAY_W-1:0] base;
        logic [SIZE_W-1:0]  size;
        logic [ARRAY_W-1:0] last;
    } resp_t;

    op_kind_e           dec_kind;
    logic               dec_count_ok;
    logic [ARRAY_W-1:0] calc_base;
    logic [SIZE_W-1:0]  calc_size;
    logic [ARRAY_W-1:0] calc_last;
    logic [NSECT-1:0]   prot_bits;
    logic [SECT_W-1:0]  cmd_sect;
    logic               permit;
    resp_t              rsp_d, rsp_q;

    assign cmd_sect = cmd_addr[SECT_SH +: SECT_W];

    flash_cmd_decode #(
        .PAGE_W (PAGE_W)
    ) u_decode (
        .op       (cmd_op),
        .count    (cmd_count),
        .kind     (dec_kind),
        .count_ok (dec_count_ok)
    );

    flash_region_calc #(
        .ARRAY_W  (ARRAY_W),
        .SECT_SH  (SECT_SH),
        .PAGE_W   (PAGE_W),
        .SMALL_SH (SMALL_SH),
        .MID_SH   (MID_SH)
    ) u_region (
        .kind  (dec_kind),
        .addr  (cmd_addr[ARRAY_W-1:0]),
        .count (cmd_count),
        .base  (calc_base),
        .size  (calc_size),
        .last  (calc_last)
    );

    flash_prot_regs #(
        .NSECT (NSECT)
    ) u_prot (
        .clk       (clk),
        .rst_n     (rst_n),
        .prot_req  (prot_req),
        .prot_ctl  (prot_ctl_e'(prot_ctl)),
        .prot_sect (prot_sect),
        .lock_wr   (lock_wr),
        .lock_val  (lock_val),
        .wp_n      (wp_n),
        .prot_bits (prot_bits)
    );

    always_comb begin
        if (dec_kind == OPK_CHIP) begin
            permit = (prot_bits == '0);
        end else begin
            permit = !prot_bits[cmd_sect];
        end
        rsp_d        = rsp_q;
        rsp_d.grant  = 1'b0;
        rsp_d.reject = 1'b0;
        if (cmd_valid && dec_kind != OPK_NONE) begin
            rsp_d.grant  = permit && dec_count_ok;
            rsp_d.reject = !(permit && dec_count_ok);
            rsp_d.base   = calc_base;
            rsp_d.size   = calc_size;
            rsp_d.last   = calc_last;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign grant       = rsp_q.grant;
    assign reject      = rsp_q.reject;
    assign region_base = ADDR_W'(rsp_q.base);
    assign region_size = rsp_q.size;
    assign region_last = ADDR_W'(rsp_q.last);

    // R5
    grant_reject_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grant, reject}));

    // R5
    resp_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant || reject) |-> $past(cmd_valid));

    // R11
    unknown_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && dec_kind == OPK_NONE) |=> (!grant && !reject && $stable(region_base)));

    // R3
    bad_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OPC_PAGE && (cmd_count == '0 || cmd_count > (CNT_W'(1) << PAGE_W)))
        |=> reject);

    // R6
    chip_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OPC_CHIP && prot_bits != '0) |=> reject);

    // R4
    high_addr_answered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && dec_kind != OPK_NONE && cmd_addr[ADDR_W-1:ARRAY_W] != '0)
        |=> ((grant || reject) && region_base[ADDR_W-1:ARRAY_W] == '0));

    // R1
    large_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OPC_ERASE_L) |=> (region_base[SECT_SH-1:0] == '0));

endmodule

// File: tb/tb_flash_prot_check.sv
module tb_flash_prot_check;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid;
    logic [7:0]  cmd_op;
    logic [23:0] cmd_addr;
    logic [8:0]  cmd_count;
    logic        prot_req;
    logic [1:0]  prot_ctl;
    logic [4:0]  prot_sect;
    logic        lock_wr;
    logic        lock_val;
    logic        wp_n;
    logic        grant;
    logic        reject;
    logic [23:0] region_base;
    logic [21:0] region_size;
    logic [23:0] region_last;

    always #4 clk = ~clk;

    flash_prot_check dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .cmd_addr    (cmd_addr),
        .cmd_count   (cmd_count),
        .prot_req    (prot_req),
        .prot_ctl    (prot_ctl),
        .prot_sect   (prot_sect),
        .lock_wr     (lock_wr),
        .lock_val    (lock_val),
        .wp_n        (wp_n),
        .grant       (grant),
        .reject      (reject),
        .region_base (region_base),
        .region_size (region_size),
        .region_last (region_last)
    );

    typedef struct {
        logic        g;
        logic        r;
        logic        chk_reg;
        logic [23:0] base;
        logic [21:0] size;
        logic [23:0] last;
        string       tag;
    } exp_t;

    exp_t        q[$];
    logic [31:0] m_bits;
    logic        m_lock;
    int          n_vec = 0;
    int          n_bad = 0;
    logic        mon_on = 1'b0;

    function automatic logic m_frozen();
        return m_lock && !wp_n;
    endfunction

    function automatic exp_t model_cmd(input logic [7:0] op, input logic [23:0] a,
                                       input logic [8:0] cnt, input string tag,
                                       output logic known);
        exp_t        e;
        logic [20:0] aa;
        logic [21:0] sz;
        logic        ok;
        aa = a[20:0];
        known = 1'b1;
        sz = '0;
        case (op)
            8'h20:   sz = 22'd4096;
            8'h52:   sz = 22'd32768;
            8'hD8:   sz = 22'd65536;
            8'hC7:   sz = 22'h200000;
            8'h02:   sz = {13'd0, cnt};
            default: known = 1'b0;
        endcase
        if (op == 8'hC7) begin
            ok     = (m_bits == 32'd0);
            e.base = 24'd0;
            e.last = 24'h1FFFFF;
        end else if (op == 8'h02) begin
            ok     = !m_bits[aa[20:16]] && cnt >= 9'd1 && cnt <= 9'd256;
            e.base = {3'd0, aa};
            e.last = {3'd0, aa[20:8], 8'(aa[7:0] + cnt[7:0] - 8'd1)};
        end else begin
            ok     = !m_bits[aa[20:16]];
            e.base = {3'd0, aa - 21'(aa % sz[20:0])};
            e.last = e.base + 24'(sz) - 24'd1;
        end
        e.g       = ok;
        e.r       = !ok;
        e.chk_reg = ok;
        e.size    = sz;
        e.tag     = tag;
        return e;
    endfunction

    function automatic void model_prot(input logic [1:0] ctl, input logic [4:0] s);
        if (!m_frozen()) begin
            case (ctl)
                2'b00:   m_bits[s] = 1'b1;
                2'b01:   m_bits[s] = 1'b0;
                2'b10:   m_bits = '1;
                default: m_bits = '0;
            endcase
        end
    endfunction

    task automatic send_cmd(input logic [7:0] op, input logic [23:0] a,
                            input logic [8:0] cnt, input string tag);
        exp_t e;
        logic known;
        e = model_cmd(op, a, cnt, tag, known);
        if (known) q.push_back(e);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_addr  = a;
        cmd_count = cnt;
        @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_prot(input logic [1:0] ctl, input logic [4:0] s);
        model_prot(ctl, s);
        prot_req  = 1'b1;
        prot_ctl  = ctl;
        prot_sect = s;
        @(negedge clk);
        prot_req = 1'b0;
    endtask

    task automatic send_lock(input logic v);
        if (!m_frozen()) m_lock = v;
        lock_wr  = 1'b1;
        lock_val = v;
        @(negedge clk);
        lock_wr = 1'b0;
    endtask

    task automatic send_both(input logic [7:0] op, input logic [23:0] a,
                             input logic [1:0] ctl, input logic [4:0] s, input string tag);
        exp_t e;
        logic known;
        e = model_cmd(op, a, 9'd1, tag, known);
        if (known) q.push_back(e);
        model_prot(ctl, s);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_addr  = a;
        cmd_count = 9'd1;
        prot_req  = 1'b1;
        prot_ctl  = ctl;
        prot_sect = s;
        @(negedge clk);
        cmd_valid = 1'b0;
        prot_req  = 1'b0;
        @(negedge clk);
    endtask

    task automatic print_summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    // Monitor: pops expected items as responses appear
    always @(negedge clk) begin
        if (mon_on && (grant || reject)) begin
            n_vec++;
            if (q.size() == 0) begin
                n_bad++;
                $display("FAIL R11 spurious response: grant=%0b reject=%0b expected none", grant, reject);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (grant !== e.g || reject !== e.r ||
                    (e.chk_reg && (region_base !== e.base || region_size !== e.size ||
                                   region_last !== e.last))) begin
                    n_bad++;
                    $display("FAIL %s: got g=%0b r=%0b base=%h size=%h last=%h expected g=%0b r=%0b base=%h size=%h last=%h",
                             e.tag, grant, reject, region_base, region_size, region_last,
                             e.g, e.r, e.base, e.size, e.last);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        print_summary();
        $finish;
    end

    initial begin
        logic [23:0] held_base;
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_addr = '0; cmd_count = '0;
        prot_req = 1'b0; prot_ctl = '0; prot_sect = '0; lock_wr = 1'b0; lock_val = 1'b0;
        wp_n = 1'b1;
        m_bits = '1;
        m_lock = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: outputs idle after reset
        n_vec++;
        if (grant !== 1'b0 || reject !== 1'b0) begin
            n_bad++;
            $display("FAIL R10 reset outputs: g=%0b r=%0b expected 0 0", grant, reject);
        end
        mon_on = 1'b1;

        send_cmd(8'h20, 24'h001234, 9'd0, "R10 fully protected after reset");
        send_cmd(8'hD8, 24'h1F0000, 9'd0, "R10 top sector protected after reset");

        send_prot(2'b11, 5'd0);
        send_cmd(8'h20, 24'h0A5678, 9'd0, "R1 small erase");
        send_cmd(8'h52, 24'h0AD123, 9'd0, "R1 mid erase");
        send_cmd(8'hD8, 24'h1F8001, 9'd0, "R1 large erase top sector");
        send_cmd(8'hD8, 24'hE34567, 9'd0, "R4 upper address bits ignored");

        send_cmd(8'h02, 24'h0123F0, 9'd32,  "R2 page wrap");
        send_cmd(8'h02, 24'h012300, 9'd256, "R2 full page");
        send_cmd(8'h02, 24'h1FFFFF, 9'd1,   "R2 single byte at array end");
        send_cmd(8'h02, 24'h012300, 9'd0,   "R3 zero count");
        send_cmd(8'h02, 24'h012300, 9'd257, "R3 count over page");

        send_cmd(8'hC7, 24'h000000, 9'd0, "R6 whole array unprotected");
        send_prot(2'b00, 5'd5);
        send_cmd(8'hC7, 24'h000000, 9'd0, "R6 whole array with sector 5 protected");
        send_cmd(8'h20, 24'h05F000, 9'd0, "R7 sector 5 protected");
        send_cmd(8'h20, 24'h04FFFF, 9'd0, "R5 neighbour sector 4 open");
        send_cmd(8'h02, 24'h251000, 9'd4, "R4 alias into sector 5");
        send_prot(2'b01, 5'd5);
        send_cmd(8'h20, 24'h05F000, 9'd0, "R7 sector 5 cleared");

        send_prot(2'b10, 5'd0);
        send_cmd(8'h52, 24'h130000, 9'd0, "R8 set all");
        send_prot(2'b11, 5'd0);

        send_both(8'h20, 24'h070000, 2'b00, 5'd7, "R12 same-cycle protect uses old bits");
        send_cmd(8'h20, 24'h071000, 9'd0, "R12 protect visible afterwards");

        send_lock(1'b1);
        wp_n = 1'b0;
        send_prot(2'b10, 5'd0);
        send_cmd(8'h20, 24'h090000, 9'd0, "R9 global protect ignored while locked");
        send_lock(1'b0);
        send_prot(2'b00, 5'd9);
        send_cmd(8'h20, 24'h090000, 9'd0, "R9 lock write and protect ignored");
        wp_n = 1'b1;
        @(negedge clk);
        send_prot(2'b00, 5'd9);
        send_cmd(8'h20, 24'h090000, 9'd0, "R9 protect accepted with pin high");
        wp_n = 1'b0;
        @(negedge clk);
        send_prot(2'b01, 5'd9);
        send_cmd(8'h20, 24'h090000, 9'd0, "R9 unprotect ignored while locked");
        wp_n = 1'b1;
        @(negedge clk);

        held_base = region_base;
        send_cmd(8'h03, 24'h155555, 9'd0, "R11");
        @(negedge clk);
        // R11: unknown opcode leaves outputs untouched
        n_vec++;
        if (grant !== 1'b0 || reject !== 1'b0 || region_base !== held_base) begin
            n_bad++;
            $display("FAIL R11 unknown opcode: g=%0b r=%0b base=%h expected 0 0 %h",
                     grant, reject, region_base, held_base);
        end

        repeat (3) @(negedge clk);
        n_vec++;
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL R5 missing responses: %0d pending expected 0", q.size());
        end
        print_summary();
        $finish;
    end

endmodule